// File: doc/BRIEF.md
# Routed Interrupt Source Controller

This block takes seven level-sensitive interrupt requests and turns them into six output interrupt lines. Each request belongs to one of six routing entries. Software programs each entry with a target server, a priority and an output line number (the source number). Two of the requests share entry 0 and its output line. Every other request has an entry of its own. Each request's current level is kept as a status bit. The two shared requests report in the control register, and the other five report in a separate read-only status register.

Each routing entry also shows a pending flag. The flag is not latched. It is recomputed every cycle as "request asserted and entry not masked", where a priority of all ones means masked. An output line follows the raw requests of every entry whose source number selects it, whatever the priority. The source number can be changed at run time, so software can send any entry to any line. A source number that names no line (6 or 7) is stored in the entry but drives nothing.

All observable state is registered. A request change or a register write shows on the outputs and in read data one clock later. The register port is a flat 64-bit single-cycle write port. Read data comes back combinationally from the current address.

Top module: `routed_irq_ctrl`

## Requirements
- R1: After reset, routing entry k (k = 0..5) holds server 0, priority 0xFF, source number k and pending 0. All output lines, status bits and control bits are 0 and every effective-server output is 0.
- R2: While an entry's priority field is 0xFF, its pending flag (bit 24) reads 0, whatever its request does. Writing 0xFF into an entry whose request is high clears pending one cycle after the write.
- R3: An entry's pending bit equals (request level AND NOT masked). It is re-evaluated on every request change and on every routing write, and becomes visible one cycle later.
- R4: Requests req_in[0] and req_in[1] share routing entry 0 at address 0x10. Their status is read at control-register bits 47 and 46 respectively. The line entry 0 selects stays high, and entry 0 stays pending, while either request is high.
- R5: Requests req_in[2..5] use entries 1..4 at addresses 0x16..0x19 and report at status-register bits 36, 35, 34, 33. req_in[6] uses entry 5 at address 0x1A and reports at bit 32. The status register (address 0x15) is read-only, and writes to it change nothing.
- R6: A routing write stores only the server field (bits 55:40), the priority field (bits 39:32) and the source field (bits 31:29). All other bits are ignored, including bit 24, and read back as 0. Bit 24 always shows the computed pending state.
- R7: Output eff_server[14k+13:14k] carries entry k's server field shifted right by 2. The two low bits are a link pointer and are dropped.
- R8: irq_line[s] is high one cycle after any entry whose source field equals s has its request high, whatever that entry's priority. Several entries on one line are ORed together.
- R9: A source field of 6 or 7 is stored and reads back, but drives no output line.
- R10: The control register at 0x0E is written directly at 0x0E, OR-set through 0x12 and cleared through 0x13 (bits set in the data are cleared). Its bits 47:46 always reflect the registered requests and cannot be written by software.
- R11: A read of any unmapped address returns all ones. A write to it changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | 7 | Level interrupt requests; bits 0 and 1 share entry 0, bit n+1 feeds entry n for n = 1..5 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register index for read and write |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for reg_addr (combinational) |
| irq_line | output | 6 | Registered output interrupt lines, one per source number |
| eff_server | output | 84 | Effective server of each entry, 14 bits per entry |

## Verification
The hardest case to reach is two entries landing on the same output line with different request timing. The stimulus remaps entry 5 onto line 3, which entry 3 already uses by default, then raises and drops their requests in overlapping order so the line must stay high until the last one falls. The shared entry 0 is driven the same way, with its two requests released one at a time. Pending is also checked at the moment a mask write lands while the request is still high, so that a write alone has to clear it. Latency is checked by sampling the lines in the cycle a request changes, when they must still hold the old value.

// File: rtl/isc_pkg.sv
package isc_pkg;

    parameter int NUM_ENTRIES = 6;
    parameter int NUM_REQ     = NUM_ENTRIES + 1;
    parameter int NUM_LINES   = 6;
    parameter int DATA_W      = 64;
    parameter int ADDR_W      = 5;
    parameter int SRV_W       = 16;
    parameter int PRIO_W      = 8;
    parameter int SRC_W       = 3;
    parameter int LINK_BITS   = 2;

    localparam int EFF_SRV_W  = SRV_W - LINK_BITS;
    localparam int SRV_LSB    = 40;
    localparam int PRIO_LSB   = 32;
    localparam int SRC_LSB    = 29;
    localparam int PEND_BIT   = 24;

    localparam logic [ADDR_W-1:0] ADDR_CTRL  = ADDR_W'(5'h0E);
    localparam logic [ADDR_W-1:0] ADDR_CSET  = ADDR_W'(5'h12);
    localparam logic [ADDR_W-1:0] ADDR_CCLR  = ADDR_W'(5'h13);
    localparam logic [ADDR_W-1:0] ADDR_STAT  = ADDR_W'(5'h15);
    localparam logic [ADDR_W-1:0] ADDR_SHARE = ADDR_W'(5'h10);
    localparam logic [ADDR_W-1:0] ADDR_SOLO0 = ADDR_W'(5'h16);

    localparam int CTRL_REQA_BIT = 47;
    localparam int CTRL_REQB_BIT = 46;
    localparam int STAT_TOP_BIT  = 37;

    localparam logic [DATA_W-1:0] CTRL_HW_MASK =
        (DATA_W'(1) << CTRL_REQA_BIT) | (DATA_W'(1) << CTRL_REQB_BIT);

    typedef struct packed {
        logic [SRV_W-1:0]  server;
        logic [PRIO_W-1:0] prio;
        logic [SRC_W-1:0]  src;
    } route_t;

    typedef enum logic [1:0] {
        CW_NONE,
        CW_LOAD,
        CW_SET,
        CW_CLEAR
    } ctrl_op_e;

    function automatic route_t route_from_word(input logic [DATA_W-1:0] w);
        route_t r;
        r.server = w[SRV_LSB  +: SRV_W];
        r.prio   = w[PRIO_LSB +: PRIO_W];
        r.src    = w[SRC_LSB  +: SRC_W];
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] route_to_word(input route_t r,
                                                         input logic pend);
        logic [DATA_W-1:0] w;
        w = '0;
        w[SRV_LSB  +: SRV_W]  = r.server;
        w[PRIO_LSB +: PRIO_W] = r.prio;
        w[SRC_LSB  +: SRC_W]  = r.src;
        w[PEND_BIT]           = pend;
        return w;
    endfunction

    function automatic logic prio_masked(input route_t r);
        return r.prio == '1;
    endfunction

    function automatic logic [ADDR_W-1:0] entry_addr(input int e);
        if (e == 0) return ADDR_SHARE;
        return ADDR_SOLO0 + ADDR_W'(e - 1);
    endfunction

endpackage

// File: rtl/isc_route_entry.sv
module isc_route_entry
    import isc_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_hit,
    input  route_t               wr_route,
    input  logic                 active,
    output route_t               route_q,
    output logic [SRC_W-1:0]     src_d,
    output logic                 pending_q
);

    route_t route_d;

    always_comb begin
        route_d = wr_hit ? wr_route : route_q;
        src_d   = route_d.src;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            route_q.server <= '0;
            route_q.prio   <= '1;
            route_q.src    <= SRC_W'(IDX);
            pending_q      <= 1'b0;
        end else begin
            route_q   <= route_d;
            pending_q <= active && !prio_masked(route_d);
        end
    end

    // R1: reset contents of the entry
    p_reset_entry_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (route_q.prio == '1 && route_q.src == SRC_W'(IDX) &&
                        route_q.server == '0 && !pending_q));

    // R2: a masked entry never shows pending
    p_mask_idle_r2: assert property (@(posedge clk) disable iff (rst)
        pending_q |-> (route_q.prio != '1));

    // R3: pending only follows a request that was high
    p_pend_req_r3: assert property (@(posedge clk) disable iff (rst)
        pending_q |-> $past(active));

    // R6: fields only move on a write
    p_hold_route_r6: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_hit) |-> $stable(route_q));

endmodule

// File: rtl/isc_line_map.sv
module isc_line_map
    import isc_pkg::*;
(
    input  logic                                clk,
    input  logic                                rst,
    input  logic [NUM_ENTRIES-1:0]              active,
    input  logic [NUM_ENTRIES-1:0][SRC_W-1:0]   src_sel,
    output logic [NUM_LINES-1:0]                line_q
);

    logic [NUM_LINES-1:0] line_d;

    for (genvar s = 0; s < NUM_LINES; s++) begin : g_line
        always_comb begin
            line_d[s] = 1'b0;
            for (int e = 0; e < NUM_ENTRIES; e++) begin
                if (active[e] && (src_sel[e] == SRC_W'(s)))
                    line_d[s] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) line_q <= '0;
        else     line_q <= line_d;
    end

    // R8: a line can only be high after some request was high
    p_quiet_lines_r8: assert property (@(posedge clk) disable iff (rst)
        (|line_q) |-> $past(|active));

endmodule

// File: rtl/routed_irq_ctrl.sv
module routed_irq_ctrl
    import isc_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NUM_REQ-1:0]                req_in,
    input  logic                              reg_wr,
    input  logic [ADDR_W-1:0]                 reg_addr,
    input  logic [DATA_W-1:0]                 reg_wdata,
    output logic [DATA_W-1:0]                 reg_rdata,
    output logic [NUM_LINES-1:0]              irq_line,
    output logic [NUM_ENTRIES*EFF_SRV_W-1:0]  eff_server
);

    logic [NUM_ENTRIES-1:0]            active;
    logic [NUM_ENTRIES-1:0]            pending_q;
    logic [NUM_ENTRIES-1:0][SRC_W-1:0] src_d;
    route_t                            route_q [NUM_ENTRIES];
    route_t                            wr_route;
    logic [NUM_REQ-1:0]                status_q;
    logic [DATA_W-1:0]                 ctrl_sw_q;
    logic [DATA_W-1:0]                 ctrl_d;
    ctrl_op_e                          ctrl_op;

    assign wr_route = route_from_word(reg_wdata);

    // entry 0 merges the two shared requests; the rest map one to one
    assign active[0] = req_in[0] | req_in[1];
    for (genvar e = 1; e < NUM_ENTRIES; e++) begin : g_act
        assign active[e] = req_in[e+1];
    end

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
        isc_route_entry #(.IDX(e)) u_entry (
            .clk       (clk),
            .rst       (rst),
            .wr_hit    (reg_wr && (reg_addr == entry_addr(e))),
            .wr_route  (wr_route),
            .active    (active[e]),
            .route_q   (route_q[e]),
            .src_d     (src_d[e]),
            .pending_q (pending_q[e])
        );
        assign eff_server[e*EFF_SRV_W +: EFF_SRV_W] =
            route_q[e].server[SRV_W-1:LINK_BITS];
    end

    isc_line_map u_map (
        .clk     (clk),
        .rst     (rst),
        .active  (active),
        .src_sel (src_d),
        .line_q  (irq_line)
    );

    always_comb begin
        ctrl_op = CW_NONE;
        if (reg_wr) begin
            case (reg_addr)
                ADDR_CTRL: ctrl_op = CW_LOAD;
                ADDR_CSET: ctrl_op = CW_SET;
                ADDR_CCLR: ctrl_op = CW_CLEAR;
                default:   ctrl_op = CW_NONE;
            endcase
        end
        case (ctrl_op)
            CW_LOAD:  ctrl_d = reg_wdata;
            CW_SET:   ctrl_d = ctrl_sw_q | reg_wdata;
            CW_CLEAR: ctrl_d = ctrl_sw_q & ~reg_wdata;
            default:  ctrl_d = ctrl_sw_q;
        endcase
        ctrl_d = ctrl_d & ~CTRL_HW_MASK;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q  <= '0;
            ctrl_sw_q <= '0;
        end else begin
            status_q  <= req_in;
            ctrl_sw_q <= ctrl_d;
        end
    end

    always_comb begin
        reg_rdata = '1;
        if (reg_addr == ADDR_CTRL) begin
            reg_rdata = ctrl_sw_q;
            reg_rdata[CTRL_REQA_BIT] = status_q[0];
            reg_rdata[CTRL_REQB_BIT] = status_q[1];
        end else if (reg_addr == ADDR_STAT) begin
            reg_rdata = '0;
            for (int e = 1; e < NUM_ENTRIES; e++)
                reg_rdata[STAT_TOP_BIT-e] = status_q[e+1];
        end
        for (int e = 0; e < NUM_ENTRIES; e++) begin
            if (reg_addr == entry_addr(e))
                reg_rdata = route_to_word(route_q[e], pending_q[e]);
        end
    end

endmodule

// File: tb/routed_irq_ctrl_bench.sv
module routed_irq_ctrl_bench;
    import isc_pkg::*;

    logic                             clk = 1'b0;
    logic                             rst = 1'b1;
    logic [NUM_REQ-1:0]               req_in = '0;
    logic                             reg_wr = 1'b0;
    logic [ADDR_W-1:0]                reg_addr = '0;
    logic [DATA_W-1:0]                reg_wdata = '0;
    logic [DATA_W-1:0]                reg_rdata;
    logic [NUM_LINES-1:0]             irq_line;
    logic [NUM_ENTRIES*EFF_SRV_W-1:0] eff_server;

    routed_irq_ctrl u_routed_irq_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req_in     (req_in),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq_line   (irq_line),
        .eff_server (eff_server)
    );

    always #10 clk = ~clk;   // 50 MHz

    typedef struct {
        int          due;
        int          kind;   // 0 read data, 1 lines, 2 effective server
        int          sel;
        logic [63:0] exp;
        string       tag;
    } item_t;

    item_t       sb [$];
    item_t       it;
    int          cyc = 0;
    int          vectors = 0;
    int          miscompares = 0;
    bit          done = 1'b0;
    logic [63:0] act;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pops expectations due in this cycle
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            it = sb.pop_front();
            case (it.kind)
                0:       act = reg_rdata;
                1:       act = 64'(irq_line);
                default: act = 64'(eff_server[it.sel*EFF_SRV_W +: EFF_SRV_W]);
            endcase
            vectors++;
            if (act !== it.exp) begin
                miscompares++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    always @(posedge clk) begin
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic push(input int kind, input int sel, input logic [63:0] exp,
                        input string tag);
        item_t n;
        n.due = cyc; n.kind = kind; n.sel = sel; n.exp = exp; n.tag = tag;
        sb.push_back(n);
    endtask

    task automatic wr(input logic [4:0] a, input logic [63:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [63:0] exp, input string tag);
        reg_addr = a;
        push(0, 0, exp, tag);
        tick();
    endtask

    task automatic lines(input logic [5:0] exp, input string tag);
        push(1, 0, 64'(exp), tag);
        tick();
    endtask

    task automatic srv(input int e, input logic [13:0] exp, input string tag);
        push(2, e, 64'(exp), tag);
        tick();
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1 reset state
        rd(5'h10, 64'h0000_00FF_0000_0000, "R1 entry0 reset");
        rd(5'h17, 64'h0000_00FF_4000_0000, "R1 entry2 reset");
        rd(5'h1A, 64'h0000_00FF_A000_0000, "R1 entry5 reset");
        rd(5'h15, 64'h0, "R1 status reset");
        rd(5'h0E, 64'h0, "R1 ctrl reset");
        lines(6'h00, "R1 lines reset");
        srv(5, 14'h0, "R1 server reset");

        // R8 masked entry still drives its line; R2 pending stays 0
        req_in[2] = 1'b1;
        lines(6'h00, "R8 latency old value");
        lines(6'h02, "R8 line1 from entry1");
        rd(5'h16, 64'h0000_00FF_2000_0000, "R2 masked no pending");
        rd(5'h15, 64'h0000_0010_0000_0000, "R5 status bit36");

        // R6/R3 unmask by write with junk bits and bit 24
        wr(5'h16, 64'hAB01_0405_2100_00FF);
        rd(5'h16, 64'h0001_0405_2100_0000, "R6 fields stored, R3 pending");
        srv(1, 14'h041, "R7 effective server");

        // R2 mask write while request high clears pending
        wr(5'h16, 64'h0001_04FF_2000_0000);
        rd(5'h16, 64'h0001_04FF_2000_0000, "R2 mask write clears pending");
        wr(5'h16, 64'h0001_0405_2000_0000);
        rd(5'h16, 64'h0001_0405_2100_0000, "R3 unmask write sets pending");

        req_in[2] = 1'b0;
        tick();
        rd(5'h16, 64'h0001_0405_2000_0000, "R3 pending follows drop");
        lines(6'h00, "R8 line1 released");
        wr(5'h16, 64'h0001_0405_2100_0000);
        rd(5'h16, 64'h0001_0405_2000_0000, "R6 bit24 write ignored");

        // R4 shared entry
        wr(5'h10, 64'h0000_0003_0000_0000);
        req_in[1:0] = 2'b11;
        tick();
        lines(6'h01, "R4 shared line both");
        rd(5'h0E, 64'h0000_C000_0000_0000, "R4 ctrl bits 47 46");
        rd(5'h10, 64'h0000_0003_0100_0000, "R4 shared pending");
        req_in[1:0] = 2'b10;
        tick();
        lines(6'h01, "R4 line held by second request");
        rd(5'h0E, 64'h0000_4000_0000_0000, "R4 ctrl bit46 only");
        rd(5'h10, 64'h0000_0003_0100_0000, "R4 pending held");
        req_in[1:0] = 2'b00;
        tick();
        lines(6'h00, "R4 line drops after both");
        rd(5'h10, 64'h0000_0003_0000_0000, "R4 pending drops");

        // R8 remap entry5 onto line 3, OR with entry3
        wr(5'h1A, 64'h0000_00FF_6000_0000);
        req_in[6] = 1'b1;
        tick();
        lines(6'h08, "R8 remapped to line3");
        rd(5'h15, 64'h0000_0001_0000_0000, "R5 status bit32");
        req_in[4] = 1'b1;
        tick();
        req_in[6] = 1'b0;
        tick();
        lines(6'h08, "R8 line3 held by entry3");
        req_in = '0;
        tick();
        lines(6'h00, "R8 line3 released");

        // R9 invalid source number
        wr(5'h19, 64'h0000_00FF_E000_0000);
        req_in[5] = 1'b1;
        tick();
        lines(6'h00, "R9 source 7 drives nothing");
        rd(5'h19, 64'h0000_00FF_E000_0000, "R9 source 7 stored");
        rd(5'h15, 64'h0000_0002_0000_0000, "R5 status bit33");
        wr(5'h15, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(5'h15, 64'h0000_0002_0000_0000, "R5 status write ignored");
        req_in = '0;
        tick();

        // R10 control register
        wr(5'h0E, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(5'h0E, 64'hFFFF_3FFF_FFFF_FFFF, "R10 load keeps hw bits");
        wr(5'h13, 64'hF000_0000_0000_0000);
        rd(5'h0E, 64'h0FFF_3FFF_FFFF_FFFF, "R10 clear alias");
        wr(5'h0E, 64'h0);
        wr(5'h12, 64'h0000_C000_0000_0001);
        rd(5'h0E, 64'h0000_0000_0000_0001, "R10 set alias");
        req_in[0] = 1'b1;
        tick();
        rd(5'h0E, 64'h0000_8000_0000_0001, "R10 hw bit47 live");
        req_in = '0;
        tick();

        // R11 unmapped addresses
        rd(5'h00, 64'hFFFF_FFFF_FFFF_FFFF, "R11 unmapped read");
        wr(5'h03, 64'h0);
        rd(5'h03, 64'hFFFF_FFFF_FFFF_FFFF, "R11 unmapped write");
        rd(5'h10, 64'h0000_0003_0000_0000, "R11 entry0 untouched");

        repeat (3) tick();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule